// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of N bits each (N defaults to 32) over several clock cycles and returns the full 2N-bit signed product. A pulse on the start input while the block is idle captures both operands and begins a run. The multiplier sits in the low half of a combined product register, and one extra bit sits to its right. The upper half starts at zero and carries one guard bit.

On each cycle, the lowest bit of the multiplier field and the extra bit form a pair. That pair selects whether the multiplicand is subtracted from the upper half, added to it, or left alone. The whole register then shifts right by one place, and the sign bit is copied into the vacated top position. After N such steps the product is valid, and the block raises done for one cycle. It then holds the product until the next run is accepted.

Top module: `booth_mul_seq`

## Requirements
- R1: Each step recodes the pair {multiplier field LSB, extra bit}. The pair 10 subtracts the multiplicand from the upper half and 01 adds it. Pairs 00 and 11 leave the upper half unchanged before the shift.
- R2: When the run ends, product_o equals the signed 2N-bit product of the two operands captured at start, for every combination of operand signs. For N=4, 2 x 7 gives 8'h0E and 2 x -3 gives 8'hFA.
- R3: The most negative operand value gives the correct product in either position or in both. For N=4, -8 x -8 gives 8'h40 and -8 x 7 gives 8'hC8. The upper half keeps a guard bit so that no intermediate sum wraps.
- R4: done_o rises after the (N+1)-th rising clock edge, counting the edge that accepts start as the first. This is one load edge followed by N step edges.
- R5: start_i is accepted only while busy_o is low. busy_o is high from the accepting edge until the end of the run. A start pulse while busy changes neither the result nor the timing of the current run.
- R6: done_o is high for exactly one cycle per run, and busy_o is low whenever done_o is high.
- R7: After done_o, product_o holds its value until the next accepted start.
- R8: After reset, busy_o is 0, done_o is 0 and product_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; ignored while busy |
| mcand_i | input | N | Signed multiplicand, captured on accepted start |
| mplier_i | input | N | Signed multiplier, captured on accepted start |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when product_o becomes valid |
| product_o | output | 2N | Signed product |

## Verification
A 4-bit instance is swept over all 256 operand pairs. This sweep exercises every run of ones and zeros in the multiplier, and every multiplicand sign, against an arithmetic reference. It separates a wrong recoding or a logical shift from a correct one. A 32-bit instance at the default size is run on every pairing of 0, 1, -1, the most positive and the most negative value, plus random pairs. These cases expose a missing guard bit, which only matters when subtracting the most negative multiplicand. Separate runs inject a start pulse mid-run and idle after done. They show that the result and the latency are unaffected, and that the product is held.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      right_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, right_i})
      2'b10:   op_o = OP_SUB;  // run of ones begins
      2'b01:   op_o = OP_ADD;  // run of ones ends
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N:0]   acc_i,
  input  logic [N-1:0] low_i,
  input  logic         xbit_i,
  input  logic [N-1:0] mcand_i,
  output logic [N:0]   acc_o,
  output logic [N-1:0] low_o,
  output logic         xbit_o
);
  booth_op_e  op;
  logic [N:0] mc_ext;
  logic [N:0] sum;

  booth_recode u_rec (
    .cur_i  (low_i[0]),
    .right_i(xbit_i),
    .op_o   (op)
  );

  assign mc_ext = {mcand_i[N-1], mcand_i};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc_i + mc_ext;
      OP_SUB:  sum = acc_i - mc_ext;
      default: sum = acc_i;
    endcase
  end

  // arithmetic right shift of {sum, low, xbit}
  assign acc_o  = {sum[N], sum[N:1]};
  assign low_o  = {sum[0], low_i[N-1:1]};
  assign xbit_o = low_i[0];
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);  // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);  // R6
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !done_q));  // R5
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq #(
  parameter int N = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  logic [N:0]   acc_q, acc_d;
  logic [N-1:0] low_q, low_d;
  logic [N-1:0] mcand_q;
  logic         x_q, x_d;
  logic         load, step;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_step #(.N(N)) u_step (
    .acc_i  (acc_q),
    .low_i  (low_q),
    .xbit_i (x_q),
    .mcand_i(mcand_q),
    .acc_o  (acc_d),
    .low_o  (low_d),
    .xbit_o (x_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      low_q   <= '0;
      x_q     <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      low_q   <= mplier_i;
      x_q     <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step) begin
      acc_q <= acc_d;
      low_q <= low_d;
      x_q   <= x_d;
    end
  end

  assign product_o = {acc_q[N-1:0], low_q};

  AST_ACC_SIGN_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q[N] == acc_q[N-1]);  // R3
  AST_NOP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && (low_q[0] == x_q)) |=> (acc_q[N-1:0] == $past(acc_q[N:1])));  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));  // R7
endmodule

// File: tb/sim_booth_mul_seq.sv
`timescale 1ns/1ps
module sim_booth_mul_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // 4-bit instance, exhaustive
  logic       s4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4;
  logic [7:0] p4;

  booth_mul_seq #(.N(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s4),
    .mcand_i(a4), .mplier_i(b4),
    .busy_o(busy4), .done_o(done4), .product_o(p4)
  );

  // default-size instance
  logic        s32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        busy32, done32;
  logic [63:0] p32;

  booth_mul_seq u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s32),
    .mcand_i(a32), .mplier_i(b32),
    .busy_o(busy32), .done_o(done32), .product_o(p32)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one run on u0; inject=1 pulses start again mid-run with other operands
  task automatic run4(input logic [3:0] a, input logic [3:0] b, input bit inject, input string req);
    int lat;
    int ai, bi;
    logic [7:0] exp;
    ai = a[3] ? int'(a) - 16 : int'(a);
    bi = b[3] ? int'(b) - 16 : int'(b);
    exp = 8'(ai * bi);
    @(negedge clk);
    a4 = a; b4 = b; s4 = 1'b1;
    lat = 0;
    @(negedge clk);
    lat++;
    s4 = 1'b0;
    while (!done4 && lat < 20) begin
      if (inject && lat == 2) begin
        s4 = 1'b1; a4 = ~a; b4 = ~b;
      end else s4 = 1'b0;
      @(negedge clk);
      lat++;
    end
    s4 = 1'b0;
    check(req, {56'd0, p4}, {56'd0, exp});
    if (inject) begin
      check("R5 latency with mid-run start", 64'(lat), 64'd5);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input string req);
    int lat;
    longint e;
    e = longint'($signed(a)) * longint'($signed(b));
    @(negedge clk);
    a32 = a; b32 = b; s32 = 1'b1;
    @(negedge clk);
    s32 = 1'b0;
    lat = 1;
    while (!done32 && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(req, p32, 64'(e));
  endtask

  initial begin
    logic [31:0] cv [5];
    int lat;
    cv[0] = 32'd0; cv[1] = 32'd1; cv[2] = 32'hFFFF_FFFF;
    cv[3] = 32'h7FFF_FFFF; cv[4] = 32'h8000_0000;

    #1;
    // R8: reset state
    check("R8 busy", {63'd0, busy4}, 64'd0);
    check("R8 done", {63'd0, done4}, 64'd0);
    check("R8 product", {56'd0, p4}, 64'd0);
    check("R8 product wide", p32, 64'd0);
    #24 rst_n = 1'b1;

    // R2 worked examples
    run4(4'd2, 4'd7, 1'b0, "R2 2x7");
    check("R2 2x7 value", {56'd0, p4}, 64'h0E);
    run4(4'd2, 4'hD, 1'b0, "R2 2x-3");
    check("R2 2x-3 value", {56'd0, p4}, 64'hFA);
    // R3 most negative
    run4(4'h8, 4'h8, 1'b0, "R3 -8x-8");
    check("R3 -8x-8 value", {56'd0, p4}, 64'h40);
    run4(4'h8, 4'h7, 1'b0, "R3 -8x7");
    check("R3 -8x7 value", {56'd0, p4}, 64'hC8);

    // R4/R6 latency and pulse width
    @(negedge clk);
    a4 = 4'd3; b4 = 4'd5; s4 = 1'b1;
    @(negedge clk);
    s4 = 1'b0;
    lat = 1;
    check("R5 busy after accept", {63'd0, busy4}, 64'd1);
    while (!done4 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R4 latency", 64'(lat), 64'd5);
    check("R6 busy low with done", {63'd0, busy4}, 64'd0);
    @(negedge clk);
    check("R6 done one cycle", {63'd0, done4}, 64'd0);
    // R7 hold while idle
    repeat (3) @(negedge clk);
    check("R7 product held", {56'd0, p4}, 64'd15);

    // R5 start during busy ignored
    run4(4'd6, 4'hB, 1'b1, "R5 result with mid-run start");
    run4(4'h9, 4'h3, 1'b1, "R5 result with mid-run start 2");

    // R1/R2 exhaustive sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run4(4'(i), 4'(j), 1'b0, "R1/R2 sweep");

    // default size: corners then random
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        run32(cv[i], cv[j], "R3 wide corner");
    for (int k = 0; k < 40; k++)
      run32($urandom, $urandom, "R2 wide random");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule